// File: doc/BRIEF.md
# CSMA/CD Deferral and Backoff Controller

This block decides when a half-duplex transmitter may start a frame on a shared medium. While the medium is quiet it times an inter-frame gap in two phases, counting strobes from a bit-time tick input. The first phase is 64 bit times, and carrier seen during it sends the count back to zero. The second phase is 32 bit times and does not look at carrier. When both phases complete, the block raises `tx_permit`.

When a collision has been jammed, the transmitter pulses `collision`. The block then increments its attempt count and draws a random slot count r. The value r lies in the range 0 to 2^k - 1, where k is the attempt count capped at 10. The block holds `backoff_busy` for r slot times, each slot being `SLOT_BITS` bit times. After that it runs a full inter-frame gap again before it permits a retry.

A pulse on `tx_ok` marks a frame sent without collision. It clears the attempt count and starts a fresh gap. The random values come from a free-running 16-bit LFSR inside the block.

Top module: `csma_defer_ctrl`

## Requirements
- R1: With a `bit_tick` strobe on every clock and carrier low, `tx_permit` rises exactly 96 bit ticks after the gap starts. Clocks without a tick do not advance the gap, so with a tick on every second clock the gap takes 192 clocks.
- R2: Carrier seen on any clock of the first 64-tick phase resets that phase to zero. Counting resumes only once carrier is low again, and a full 96 ticks are then needed.
- R3: Carrier during the last 32 ticks of the gap has no effect on when `tx_permit` rises. Carrier while `tx_permit` is high does not lower it.
- R4: A `tx_ok` pulse restarts the gap from zero and lowers `tx_permit`. It also clears `attempt_cnt` and `excess_col` on the next clock edge.
- R5: A `collision` pulse makes `backoff_busy` high and `tx_permit` low from the next clock edge. It also increments `attempt_cnt`, which saturates at 16.
- R6: `backoff_busy` stays high for r × `SLOT_BITS` bit ticks, with r drawn uniformly from 0 to 2^k - 1 and k = min(`attempt_cnt`, 10). When r = 0, `backoff_busy` is high for exactly one clock.
- R7: When `backoff_busy` falls, `tx_permit` stays low until a complete 96-tick gap (R1, R2, R3) has run.
- R8: `excess_col` is high exactly when `attempt_cnt` has reached 16, which happens on the 16th collision without an intervening `tx_ok`.
- R9: Out of reset, `tx_permit`, `backoff_busy`, `excess_col` and `attempt_cnt` are all zero, and the gap starts from zero.
- R10: The drawn values of r vary from attempt to attempt. Across attempts 3 to 16, at least two different values of r occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-clock strobe per bit time |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | One-clock pulse after a collision has been jammed |
| tx_ok | input | 1 | One-clock pulse after a frame sent without collision |
| tx_permit | output | 1 | Transmitter may start a frame |
| backoff_busy | output | 1 | Backoff wait in progress |
| excess_col | output | 1 | Attempt count has reached its limit |
| attempt_cnt | output | 5 | Collisions since the last successful frame, saturating |

## Verification
The assertions take `collision` and `tx_ok` to be single-clock pulses that never arrive on the same clock. They also take `bit_tick` to be a strobe rather than a level. A collision is assumed to be reported only while a frame could be in flight, that is, while `tx_permit` is high. The stimulus meets these assumptions as follows:
- It pulses each control for exactly one clock.
- It raises `collision` only after observing `tx_permit`.
- It holds `bit_tick` either on every clock or on alternate clocks.
- It shortens the slot to 4 bit ticks, so that backoffs at the full exponent of 10 finish quickly.

// File: rtl/csma_pkg.sv
// Shared types for the deferral and backoff controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package csma_pkg;

    // Phases of the inter-frame gap timer.
    typedef enum logic [1:0] {
        GAP_PH1  = 2'd0,   // carrier-sensitive phase
        GAP_PH2  = 2'd1,   // carrier-blind phase
        GAP_OPEN = 2'd2    // gap complete, medium may be used
    } gap_phase_e;

endpackage

// File: rtl/csma_lfsr.sv
// Free-running Galois LFSR supplying the low OUT_W bits as a random draw.
// Assumes SEED is nonzero and TAPS describes a maximal-length polynomial.
module csma_lfsr #(
    parameter int          W     = 16,
    parameter int          OUT_W = 10,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rand_o
);

    logic [W-1:0] state_q;

    // Advance the register by one step on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
        end
    end

    assign rand_o = state_q[OUT_W-1:0];

    // R10
    lfsr_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/csma_gap_timer.sv
// Two-phase inter-frame gap timer. Phase one restarts on carrier; phase two
// ignores carrier. Counts only on bit_tick strobes while run is high.
// Assumes restart and run come from the controller and bit_tick is a strobe.
module csma_gap_timer
    import csma_pkg::*;
#(
    parameter int IFG1_BITS = 64,
    parameter int IFG2_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic bit_tick,
    input  logic carrier,
    output logic gap_done
);

    localparam int MAXB = (IFG1_BITS > IFG2_BITS) ? IFG1_BITS : IFG2_BITS;
    localparam int CW   = $clog2(MAXB + 1);
    localparam logic [CW-1:0] LAST1 = CW'(IFG1_BITS - 1);
    localparam logic [CW-1:0] LAST2 = CW'(IFG2_BITS - 1);

    gap_phase_e    phase_q;
    logic [CW-1:0] cnt_q;

    // Phase and bit-count sequencing of the gap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= GAP_PH1;
            cnt_q   <= '0;
        end else if (run) begin
            case (phase_q)
                GAP_PH1: begin
                    if (carrier) begin
                        cnt_q <= '0;
                    end else if (bit_tick) begin
                        if (cnt_q == LAST1) begin
                            phase_q <= GAP_PH2;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                GAP_PH2: begin
                    if (bit_tick) begin
                        if (cnt_q == LAST2) begin
                            phase_q <= GAP_OPEN;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    phase_q <= GAP_OPEN;
                end
            endcase
        end
    end

    assign gap_done = (phase_q == GAP_OPEN);

    // R2
    ph1_carrier_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == GAP_PH1 && carrier && run && !restart) |=> (phase_q == GAP_PH1 && cnt_q == '0));

    // R3
    ph2_carrier_blind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == GAP_PH2 && run && !restart && !(bit_tick && cnt_q == LAST2)) |=> phase_q == GAP_PH2);

    // R1
    open_after_ph2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gap_done) |-> $past(phase_q == GAP_PH2 && cnt_q == LAST2 && bit_tick));

endmodule

// File: rtl/csma_backoff.sv
// Attempt counter and truncated binary exponential backoff wait.
// On start, draws r = rand_in masked to k = min(attempts, MAX_EXP) bits and
// waits r slots of SLOT_BITS ticks. Assumes start and clear_att are pulses.
module csma_backoff #(
    parameter int SLOT_BITS     = 512,
    parameter int MAX_EXP       = 10,
    parameter int ATTEMPT_LIMIT = 16,
    localparam int AW = $clog2(ATTEMPT_LIMIT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               start,
    input  logic               clear_att,
    input  logic [MAX_EXP-1:0] rand_in,
    output logic               busy,
    output logic               done,
    output logic [AW-1:0]      att_o,
    output logic               excess
);

    localparam int SW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
    localparam int KW = $clog2(MAX_EXP + 1);
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_BITS - 1);
    localparam logic [AW-1:0] ATT_MAX   = AW'(ATTEMPT_LIMIT);

    logic [AW-1:0]      att_q, att_next;
    logic [KW-1:0]      k_new, k_cur;
    logic [MAX_EXP-1:0] mask, r_q;
    logic [SW-1:0]      slot_q;
    logic               active_q;

    // Next attempt number and the exponent it selects.
    always_comb begin
        att_next = (att_q == ATT_MAX) ? att_q : att_q + 1'b1;
        k_new    = (int'(att_next) > MAX_EXP) ? KW'(MAX_EXP) : KW'(att_next);
        k_cur    = (int'(att_q) > MAX_EXP) ? KW'(MAX_EXP) : KW'(att_q);
        for (int i = 0; i < MAX_EXP; i++) begin
            mask[i] = (i < int'(k_new));
        end
    end

    // Attempt counter: steps on collision, clears on success.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            att_q <= '0;
        end else if (start) begin
            att_q <= att_next;
        end else if (clear_att) begin
            att_q <= '0;
        end
    end

    // Slot-time wait: count ticks per slot, count slots down from r.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            r_q      <= '0;
            slot_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            r_q      <= rand_in & mask;
            slot_q   <= '0;
        end else if (active_q) begin
            if (r_q == '0) begin
                active_q <= 1'b0;
            end else if (bit_tick) begin
                if (slot_q == SLOT_LAST) begin
                    slot_q <= '0;
                    r_q    <= r_q - 1'b1;
                    if (r_q == MAX_EXP'(1)) active_q <= 1'b0;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end

    assign busy   = active_q;
    assign done   = active_q && !start &&
                    ((r_q == '0) || (bit_tick && slot_q == SLOT_LAST && r_q == MAX_EXP'(1)));
    assign att_o  = att_q;
    assign excess = (att_q >= ATT_MAX);

    // R6
    draw_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ((r_q >> k_cur) == '0));

    // R6
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && r_q != '0 && !bit_tick && !start) |=> (active_q && $stable(r_q) && $stable(slot_q)));

    // R5
    att_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && att_q != ATT_MAX) |=> att_q == $past(att_q) + 1'b1);

    // R4
    att_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_att && !start) |=> att_q == '0);

endmodule

// File: rtl/csma_defer_ctrl.sv
// CSMA/CD transmit gate: inter-frame gap deferral plus collision backoff.
// Assumes collision and tx_ok are single-clock pulses, never together,
// and bit_tick is a one-clock strobe per bit time.
module csma_defer_ctrl #(
    parameter int        IFG1_BITS     = 64,
    parameter int        IFG2_BITS     = 32,
    parameter int        SLOT_BITS     = 512,
    parameter int        MAX_EXP       = 10,
    parameter int        ATTEMPT_LIMIT = 16,
    parameter int        LFSR_W        = 16,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic carrier_sense,
    input  logic collision,
    input  logic tx_ok,
    output logic tx_permit,
    output logic backoff_busy,
    output logic excess_col,
    output logic [$clog2(ATTEMPT_LIMIT+1)-1:0] attempt_cnt
);

    logic [MAX_EXP-1:0] rand_draw;
    logic               bo_busy, bo_done, gap_done, gap_restart;

    // Any frame end, collision or backoff completion starts a fresh gap.
    assign gap_restart = tx_ok | collision | bo_done;

    csma_lfsr #(
        .W     (LFSR_W),
        .OUT_W (MAX_EXP),
        .SEED  (LFSR_SEED),
        .TAPS  (LFSR_TAPS)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rand_o (rand_draw)
    );

    csma_gap_timer #(
        .IFG1_BITS (IFG1_BITS),
        .IFG2_BITS (IFG2_BITS)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (gap_restart),
        .run      (!bo_busy),
        .bit_tick (bit_tick),
        .carrier  (carrier_sense),
        .gap_done (gap_done)
    );

    csma_backoff #(
        .SLOT_BITS     (SLOT_BITS),
        .MAX_EXP       (MAX_EXP),
        .ATTEMPT_LIMIT (ATTEMPT_LIMIT)
    ) u_backoff (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .start     (collision),
        .clear_att (tx_ok),
        .rand_in   (rand_draw),
        .busy      (bo_busy),
        .done      (bo_done),
        .att_o     (attempt_cnt),
        .excess    (excess_col)
    );

    assign tx_permit    = gap_done && !bo_busy;
    assign backoff_busy = bo_busy;

    // R7
    reenter_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(backoff_busy) |-> !tx_permit);

    // R5
    col_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collision |=> (backoff_busy && !tx_permit));

    // R3
    permit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_permit && !collision && !tx_ok) |=> tx_permit);

    // R8
    excess_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (collision && attempt_cnt == ($clog2(ATTEMPT_LIMIT+1))'(ATTEMPT_LIMIT - 1)) |=> excess_col);

endmodule

// File: tb/test_csma_defer_ctrl.sv
module test_csma_defer_ctrl;

    localparam int SLOT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b1;
    logic       carrier_sense = 1'b0;
    logic       collision = 1'b0;
    logic       tx_ok = 1'b0;
    logic       tx_permit, backoff_busy, excess_col;
    logic [4:0] attempt_cnt;

    int n_chk = 0;
    int n_fail = 0;

    // carrier start clock, carrier length, expected clocks to permit
    localparam int VEC [0:6][0:2] = '{
        '{9999, 0, 96}, '{10, 1, 107}, '{63, 1, 160}, '{64, 1, 96},
        '{80, 30, 96},  '{0, 20, 116}, '{40, 5, 141}
    };

    csma_defer_ctrl #(.SLOT_BITS(SLOT)) i_csma_defer_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_tick      (bit_tick),
        .carrier_sense (carrier_sense),
        .collision     (collision),
        .tx_ok         (tx_ok),
        .tx_permit     (tx_permit),
        .backoff_busy  (backoff_busy),
        .excess_col    (excess_col),
        .attempt_cnt   (attempt_cnt)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // From a gap start, count clocks until tx_permit, applying carrier.
    task automatic measure_gap(input int c, input int len, input bit half, output int n);
        int k = 0;
        while (!tx_permit && k < 5000) begin
            carrier_sense = (k >= c && k < c + len);
            bit_tick      = half ? (k % 2 == 1) : 1'b1;
            @(negedge clk);
            k++;
        end
        carrier_sense = 1'b0;
        bit_tick      = 1'b1;
        n = k;
    endtask

    task automatic pulse_ok();
        tx_ok = 1'b1;
        @(negedge clk);
        tx_ok = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n, b, r, k, first_r;
        bit seen_first, varied;
        seen_first = 0;
        varied     = 0;
        first_r    = 0;
        repeat (4) @(negedge clk);
        // R9 reset values
        check(tx_permit == 0, "R9 permit", tx_permit, 0);
        check(backoff_busy == 0, "R9 busy", backoff_busy, 0);
        check(excess_col == 0, "R9 excess", excess_col, 0);
        check(attempt_cnt == 0, "R9 attempts", attempt_cnt, 0);
        rst_n = 1'b1;
        measure_gap(9999, 0, 0, n);
        check(n == 96, "R9 R1 first gap", n, 96);

        // Vector table: R1, R2, R3
        for (int v = 0; v < 7; v++) begin
            pulse_ok();
            check(tx_permit == 0, "R4 permit drop", tx_permit, 0);
            measure_gap(VEC[v][0], VEC[v][1], 0, n);
            check(n == VEC[v][2], (VEC[v][0] <= 63 && VEC[v][1] > 0) ? "R2 gap" : "R3 gap", n, VEC[v][2]);
        end

        // R1 tick on alternate clocks
        pulse_ok();
        measure_gap(9999, 0, 1, n);
        check(n == 192, "R1 half-rate tick", n, 192);

        // R3 carrier while permitted
        carrier_sense = 1'b1;
        repeat (5) @(negedge clk);
        check(tx_permit == 1, "R3 permit held", tx_permit, 1);
        carrier_sense = 1'b0;

        // Collision series: R5, R6, R7, R8, R10
        for (int a = 1; a <= 17; a++) begin
            collision = 1'b1;
            @(negedge clk);
            collision = 1'b0;
            check(backoff_busy == 1 && tx_permit == 0, "R5 busy", backoff_busy, 1);
            check(attempt_cnt == ((a > 16) ? 16 : a), "R5 attempts", attempt_cnt, (a > 16) ? 16 : a);
            check(excess_col == (a >= 16), "R8 excess", excess_col, (a >= 16) ? 1 : 0);
            b = 0;
            while (backoff_busy && b < 10000) begin
                b++;
                @(negedge clk);
            end
            k = (a > 10) ? 10 : a;
            r = (b == 1) ? 0 : b / SLOT;
            check((b == 1) || (b % SLOT == 0 && r < (1 << k)), "R6 backoff length", b, SLOT * ((1 << k) - 1));
            if (a >= 3) begin
                if (!seen_first) begin
                    first_r    = r;
                    seen_first = 1;
                end else if (r != first_r) begin
                    varied = 1;
                end
            end
            check(tx_permit == 0, "R7 no early permit", tx_permit, 0);
            measure_gap(9999, 0, 0, n);
            check(n == 96, "R7 gap after backoff", n, 96);
        end
        check(varied, "R10 draws vary", varied, 1);

        // R4 success clears attempts and excess
        pulse_ok();
        check(attempt_cnt == 0, "R4 attempts cleared", attempt_cnt, 0);
        check(excess_col == 0, "R4 excess cleared", excess_col, 0);
        measure_gap(9999, 0, 0, n);
        check(n == 96, "R4 new gap", n, 96);

        // R5 first collision after clear gives k = 1 draw
        collision = 1'b1;
        @(negedge clk);
        collision = 1'b0;
        check(attempt_cnt == 1, "R5 restart count", attempt_cnt, 1);
        b = 0;
        while (backoff_busy && b < 10000) begin
            b++;
            @(negedge clk);
        end
        check(b == 1 || b == SLOT, "R6 k=1 length", b, SLOT);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule